// File: doc/BRIEF.md
# Host Command Decoder for Configuration RAM

This block sits between a host network link and the configuration memory of a trigger controller. It takes a stream of 16-bit words and looks for a start delimiter word. It then reads a command word and a parameter word. Depending on these, it does one of the following:

- streams a whole configuration region out of the RAM;
- writes a whole static region from the words that follow;
- performs a single-address read or write for debugging;
- raises a one-cycle request to ping every front-end board.

The RAM sits outside the block. The decoder drives a 12-bit address, write data, a write strobe, a read strobe and a region select. Region select 0 is the static region and 1 is the dynamic region. The RAM answers a read strobe with data one cycle later. Words read from the RAM leave on a 16-bit output stream with a valid flag. The static region is 436 (0x1B4) words long and the dynamic region is 64 words by default.

While a block write is taking its data words, the decoder does not interpret them. A data word equal to the delimiter therefore cannot start a new command.

Top module: `cfg_cmd_decoder`

## Requirements
- R1: While hunting for a command, any word other than the delimiter 0x0040 is dropped. It causes no RAM access, no output word and no ping, and the next delimiter still starts a command.
- R2: The sequence 0x0040, 0x0001, 0x0001 streams all 436 static words to the output in rising address order, starting at address 0.
- R3: The sequence 0x0040, 0x0001, 0x0002 streams all dynamic-region words (region select 1) in rising address order.
- R4: The sequence 0x0040, 0x0001, 0x0004, A outputs exactly one word, the static word at address A (the low 12 bits of A). The RAM read strobe is high in the cycle after A is taken.
- R5: The sequence 0x0040, 0x0001, 0x0008, A outputs exactly one word, the dynamic word at address A.
- R6: The sequence 0x0040, 0x0002, 0x0001 stores the next 436 valid words at static addresses 0 upward. Those words are never decoded as commands, even when one equals 0x0040.
- R7: The sequence 0x0040, 0x0002, 0x0002, A, D writes D to static address A with exactly one write strobe. Writes never target the dynamic region.
- R8: The sequence 0x0040, 0x0010, P (P may be any word) raises the ping output for exactly one cycle, in the cycle after P is taken, with no RAM write.
- R9: A command word other than 0x0001, 0x0002 or 0x0010, or a parameter word not listed above for its command, returns the decoder to hunting with no RAM write and no output. The next command decodes normally.
- R10: In reset and in the first cycle after reset, the write strobe, read strobe, output valid and ping are all low.
- R11: A word read from the RAM appears on the output with output valid exactly two cycles after the read strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 16 | Incoming host word |
| in_valid | input | 1 | in_word is valid this cycle |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe; data is expected one cycle later |
| ram_dyn | output | 1 | Region select: 0 static, 1 dynamic |
| ram_rdata | input | 16 | RAM read data |
| out_word | output | 16 | Outgoing data word |
| out_valid | output | 1 | out_word is valid this cycle |
| ping | output | 1 | One-cycle request to ping all front-end boards |

## Verification
The bound checker watches the following on every cycle:

- the two-cycle delay from a RAM read strobe to output valid;
- that write and read strobes are never high together;
- that writes stay in the static region and always follow an accepted input word;
- that ping lasts exactly one cycle and is never high together with a write;
- that all strobes are quiet right after reset.

Other behaviour can only be shown by the bench's scenarios. These are the content and order of streamed blocks, and that a delimiter word inside block-write data is stored rather than decoded. They also include that garbage and unknown codes leave the RAM untouched, and that single-address reads return what earlier single or block writes stored.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

  localparam logic [15:0] DELIM_W    = 16'h0040;
  localparam logic [15:0] CMD_RD     = 16'h0001;
  localparam logic [15:0] CMD_WR     = 16'h0002;
  localparam logic [15:0] CMD_PING   = 16'h0010;

  localparam logic [15:0] PRD_STAT   = 16'h0001;
  localparam logic [15:0] PRD_DYN    = 16'h0002;
  localparam logic [15:0] PRD_STAT_A = 16'h0004;
  localparam logic [15:0] PRD_DYN_A  = 16'h0008;
  localparam logic [15:0] PWR_STAT   = 16'h0001;
  localparam logic [15:0] PWR_STAT_A = 16'h0002;

  typedef enum logic [1:0] {
    OP_RD_BLK,
    OP_WR_BLK,
    OP_RD_ONE,
    OP_WR_ONE
  } op_e;

  typedef enum logic [2:0] {
    P_HUNT,
    P_CMD,
    P_PAR,
    P_ADDR,
    P_DATA
  } pstate_e;

endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
  import cfgdec_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_word,
  input  logic          in_valid,
  input  logic          busy,
  output logic          go,
  output op_e           go_op,
  output logic          go_dyn,
  output logic [AW-1:0] go_addr,
  output logic [DW-1:0] go_data,
  output logic          ping
);

  pstate_e       st_q, st_d;
  logic [DW-1:0] cmd_q;
  logic          dyn_q, dyn_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          ping_d;
  logic          take;

  // Words are only interpreted while no block transfer owns the stream.
  assign take = in_valid & ~busy;

  always_comb begin
    st_d    = st_q;
    dyn_d   = dyn_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    ping_d  = 1'b0;
    go      = 1'b0;
    go_op   = OP_RD_ONE;
    go_dyn  = 1'b0;
    go_addr = addr_q;
    go_data = in_word;
    if (take) begin
      case (st_q)
        P_HUNT: begin
          if (in_word == DELIM_W) st_d = P_CMD;
        end
        P_CMD: begin
          st_d = P_PAR;
        end
        P_PAR: begin
          st_d = P_HUNT;
          case (cmd_q)
            CMD_RD: begin
              case (in_word)
                PRD_STAT: begin
                  go    = 1'b1;
                  go_op = OP_RD_BLK;
                end
                PRD_DYN: begin
                  go     = 1'b1;
                  go_op  = OP_RD_BLK;
                  go_dyn = 1'b1;
                end
                PRD_STAT_A: begin
                  st_d  = P_ADDR;
                  dyn_d = 1'b0;
                  wr_d  = 1'b0;
                end
                PRD_DYN_A: begin
                  st_d  = P_ADDR;
                  dyn_d = 1'b1;
                  wr_d  = 1'b0;
                end
                default: st_d = P_HUNT;
              endcase
            end
            CMD_WR: begin
              case (in_word)
                PWR_STAT: begin
                  go    = 1'b1;
                  go_op = OP_WR_BLK;
                end
                PWR_STAT_A: begin
                  st_d  = P_ADDR;
                  dyn_d = 1'b0;
                  wr_d  = 1'b1;
                end
                default: st_d = P_HUNT;
              endcase
            end
            CMD_PING: ping_d = 1'b1;
            default:  st_d = P_HUNT;
          endcase
        end
        P_ADDR: begin
          if (wr_q) begin
            st_d   = P_DATA;
            addr_d = in_word[AW-1:0];
          end else begin
            go      = 1'b1;
            go_op   = OP_RD_ONE;
            go_dyn  = dyn_q;
            go_addr = in_word[AW-1:0];
            st_d    = P_HUNT;
          end
        end
        P_DATA: begin
          go      = 1'b1;
          go_op   = OP_WR_ONE;
          go_addr = addr_q;
          st_d    = P_HUNT;
        end
        default: st_d = P_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= P_HUNT;
      cmd_q  <= '0;
      dyn_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      ping   <= 1'b0;
    end else begin
      st_q   <= st_d;
      dyn_q  <= dyn_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      ping   <= ping_d;
      if (take && st_q == P_CMD) cmd_q <= in_word;
    end
  end

endmodule

// File: rtl/cfgdec_sequencer.sv
module cfgdec_sequencer
  import cfgdec_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int SD_WORDS  = 436,
  parameter int DYN_WORDS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  op_e           go_op,
  input  logic          go_dyn,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  input  logic [DW-1:0] in_word,
  input  logic          in_valid,
  output logic          busy,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_rd,
  output logic          ram_dyn
);

  localparam logic [AW-1:0] S_LAST = AW'(SD_WORDS - 1);
  localparam logic [AW-1:0] D_LAST = AW'(DYN_WORDS - 1);

  typedef enum logic [1:0] { Q_IDLE, Q_RD, Q_WR } qst_e;

  qst_e          st;
  logic [AW-1:0] cnt;
  logic [AW-1:0] last;
  logic          blk_dyn;

  assign busy = (st != Q_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= Q_IDLE;
      cnt       <= '0;
      last      <= '0;
      blk_dyn   <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      ram_rd    <= 1'b0;
      ram_dyn   <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      ram_rd <= 1'b0;
      case (st)
        Q_IDLE: begin
          if (go) begin
            case (go_op)
              OP_RD_BLK: begin
                st      <= Q_RD;
                cnt     <= '0;
                last    <= go_dyn ? D_LAST : S_LAST;
                blk_dyn <= go_dyn;
              end
              OP_WR_BLK: begin
                st   <= Q_WR;
                cnt  <= '0;
                last <= S_LAST;
              end
              OP_RD_ONE: begin
                ram_rd   <= 1'b1;
                ram_addr <= go_addr;
                ram_dyn  <= go_dyn;
              end
              default: begin
                ram_we    <= 1'b1;
                ram_addr  <= go_addr;
                ram_wdata <= go_data;
                ram_dyn   <= 1'b0;
              end
            endcase
          end
        end
        Q_RD: begin
          ram_rd   <= 1'b1;
          ram_addr <= cnt;
          ram_dyn  <= blk_dyn;
          cnt      <= cnt + 1'b1;
          if (cnt == last) st <= Q_IDLE;
        end
        Q_WR: begin
          if (in_valid) begin
            ram_we    <= 1'b1;
            ram_addr  <= cnt;
            ram_wdata <= in_word;
            ram_dyn   <= 1'b0;
            cnt       <= cnt + 1'b1;
            if (cnt == last) st <= Q_IDLE;
          end
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgdec_readout.sv
module cfgdec_readout #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ram_rd,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] out_word,
  output logic          out_valid
);

  logic rd_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d1     <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      rd_d1     <= ram_rd;
      out_valid <= rd_d1;
      if (rd_d1) out_word <= ram_rdata;
    end
  end

endmodule

// File: rtl/cfg_cmd_decoder.sv
module cfg_cmd_decoder
  import cfgdec_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int SD_WORDS  = 436,
  parameter int DYN_WORDS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_word,
  input  logic          in_valid,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_rd,
  output logic          ram_dyn,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] out_word,
  output logic          out_valid,
  output logic          ping
);

  logic          busy;
  logic          go;
  op_e           go_op;
  logic          go_dyn;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_data;

  cfgdec_parser #(.AW(AW), .DW(DW)) u_parser (
    .clk      (clk),
    .rst      (rst),
    .in_word  (in_word),
    .in_valid (in_valid),
    .busy     (busy),
    .go       (go),
    .go_op    (go_op),
    .go_dyn   (go_dyn),
    .go_addr  (go_addr),
    .go_data  (go_data),
    .ping     (ping)
  );

  cfgdec_sequencer #(
    .AW(AW), .DW(DW), .SD_WORDS(SD_WORDS), .DYN_WORDS(DYN_WORDS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_op     (go_op),
    .go_dyn    (go_dyn),
    .go_addr   (go_addr),
    .go_data   (go_data),
    .in_word   (in_word),
    .in_valid  (in_valid),
    .busy      (busy),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we),
    .ram_rd    (ram_rd),
    .ram_dyn   (ram_dyn)
  );

  cfgdec_readout #(.DW(DW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .ram_rd    (ram_rd),
    .ram_rdata (ram_rdata),
    .out_word  (out_word),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic ram_we,
  input logic ram_rd,
  input logic ram_dyn,
  input logic out_valid,
  input logic ping
);

  AST_RD_TO_OUT: assert property (@(posedge clk) disable iff (rst)
    ram_rd |-> ##2 out_valid); // R11

  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_rd)); // R6

  AST_WE_STATIC: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !ram_dyn); // R7

  AST_WE_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(in_valid)); // R6

  AST_PING_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ping |=> !ping); // R8

  AST_PING_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ping |-> !ram_we); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ram_we && !ram_rd && !out_valid && !ping)); // R10

endmodule

bind cfg_cmd_decoder cfgdec_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .ram_we    (ram_we),
  .ram_rd    (ram_rd),
  .ram_dyn   (ram_dyn),
  .out_valid (out_valid),
  .ping      (ping)
);

// File: tb/sim_cfg_cmd_decoder.sv
module sim_cfg_cmd_decoder;

  localparam int SDW = 436;
  localparam int DYW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic [11:0] ram_addr;
  logic [15:0] ram_wdata;
  logic        ram_we, ram_rd, ram_dyn;
  logic [15:0] ram_rdata = '0;
  logic [15:0] out_word;
  logic        out_valid;
  logic        ping;

  always #10 clk = ~clk;

  cfg_cmd_decoder u0 (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rd(ram_rd), .ram_dyn(ram_dyn), .ram_rdata(ram_rdata),
    .out_word(out_word), .out_valid(out_valid), .ping(ping)
  );

  // external RAM model, one cycle read latency
  logic [15:0] smem [0:SDW-1];
  logic [15:0] dmem [0:DYW-1];
  // golden contents kept from the requirements
  logic [15:0] gs [0:SDW-1];
  logic [15:0] gd [0:DYW-1];

  always @(posedge clk) begin
    if (ram_we && !ram_dyn && ram_addr < SDW) smem[ram_addr] <= ram_wdata;
    if (ram_rd) begin
      if (ram_dyn) ram_rdata <= (ram_addr < DYW) ? dmem[ram_addr] : 16'hDEAD;
      else         ram_rdata <= (ram_addr < SDW) ? smem[ram_addr] : 16'hDEAD;
    end
  end

  logic [15:0] outq [$];
  int we_n = 0;
  int ping_n = 0;
  int n_chk = 0;
  int n_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) outq.push_back(out_word);
      if (ram_we) we_n++;
      if (ping) ping_n++;
    end
  end

  // table rows: command, parameter, address, data
  localparam logic [63:0] VEC [0:8] = '{
    64'h0002_0002_0005_BEEF,
    64'h0001_0004_0005_0000,
    64'h0002_0002_01B3_1234,
    64'h0001_0004_01B3_0000,
    64'h0001_0008_0007_0000,
    64'h0001_0004_0000_0000,
    64'h0003_0001_0000_0000,
    64'h0001_0010_0000_0000,
    64'h0002_0004_0009_0000
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic read_block(input string tag, input bit dyn, input int n);
    int base, bad, first;
    base = outq.size();
    put(16'h0040); put(16'h0001); put(dyn ? 16'h0002 : 16'h0001);
    idle(n + 6);
    chk({tag, " length"}, outq.size() - base, n);
    bad = 0; first = -1;
    for (int i = 0; i < n && base + i < outq.size(); i++) begin
      if (outq[base+i] != (dyn ? gd[i] : gs[i])) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first >= 0)
      chk({tag, " content"}, outq[base+first], dyn ? gd[first] : gs[first]);
    else
      chk({tag, " content"}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < SDW; i++) begin
      smem[i] = 16'(i * 3 + 16'h0100);
      gs[i]   = 16'(i * 3 + 16'h0100);
    end
    for (int i = 0; i < DYW; i++) begin
      dmem[i] = 16'(16'hD000 + i * 5);
      gd[i]   = 16'(16'hD000 + i * 5);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base, w0, p0;
    repeat (4) @(negedge clk);
    // R10: quiet during reset and right after release
    chk("R10 reset we/rd/valid/ping", {ram_we, ram_rd, out_valid, ping}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset", {ram_we, ram_rd, out_valid, ping}, 0);

    // R1: garbage without a delimiter
    base = outq.size(); w0 = we_n; p0 = ping_n;
    put(16'h0001); put(16'h0001); put(16'h0004); put(16'h0002); put(16'h0010);
    idle(6);
    chk("R1 garbage no output", outq.size() - base, 0);
    chk("R1 garbage no write/ping", (we_n - w0) + (ping_n - p0), 0);

    // R2 / R3: block reads
    read_block("R2 static block", 1'b0, SDW);
    read_block("R3 dynamic block", 1'b1, DYW);

    // table of single-address operations and unknown codes (R4, R5, R7, R9)
    for (int k = 0; k < 9; k++) begin
      logic [15:0] c, p, a, d;
      {c, p, a, d} = VEC[k];
      base = outq.size(); w0 = we_n;
      put(16'h0040); put(c); put(p); put(a);
      if (c == 16'h0002 && p == 16'h0002) begin
        put(d);
        idle(4);
        gs[a] = d;
        chk("R7 single write strobes", we_n - w0, 1);
        chk("R7 single write stored", smem[a], d);
      end else if (c == 16'h0001 && (p == 16'h0004 || p == 16'h0008)) begin
        idle(1);
        if (k == 1) begin
          chk("R4 read strobe timing", ram_rd, 1);
          idle(1);
          chk("R11 no output at +1", out_valid, 0);
          idle(1);
          chk("R11 output at +2", out_valid, 1);
        end
        idle(4);
        chk(p == 16'h0004 ? "R4 single count" : "R5 single count", outq.size() - base, 1);
        if (outq.size() > base)
          chk(p == 16'h0004 ? "R4 single value" : "R5 single value",
              outq[base], p == 16'h0004 ? gs[a] : gd[a]);
      end else begin
        idle(6);
        chk("R9 unknown no output", outq.size() - base, 0);
        chk("R9 unknown no write", we_n - w0, 0);
      end
    end

    // R6: block write containing delimiter and command-like words
    w0 = we_n; p0 = ping_n; base = outq.size();
    put(16'h0040); put(16'h0002); put(16'h0001);
    for (int i = 0; i < SDW; i++) begin
      logic [15:0] v;
      v = 16'((i * 7) ^ 16'hA5C3);
      if (i == 3) v = 16'h0040;
      if (i == 4) v = 16'h0001;
      if (i == 5) v = 16'h0004;
      gs[i] = v;
      put(v);
    end
    idle(5);
    chk("R6 block write strobes", we_n - w0, SDW);
    chk("R6 block write no output/ping", (outq.size() - base) + (ping_n - p0), 0);
    chk("R6 delimiter stored as data", smem[3], 16'h0040);
    read_block("R6 readback", 1'b0, SDW);

    // R8: ping
    w0 = we_n; p0 = ping_n;
    put(16'h0040); put(16'h0010); put(16'h1234);
    idle(1);
    chk("R8 ping high", ping, 1);
    idle(1);
    chk("R8 ping one cycle", ping, 0);
    idle(3);
    chk("R8 ping count and no write", (ping_n - p0) * 16 + (we_n - w0), 16);

    // R9: unknown command followed at once by a valid single read
    base = outq.size();
    put(16'h0040); put(16'h7777); put(16'h0001);
    put(16'h0040); put(16'h0001); put(16'h0004); put(16'h0002);
    idle(6);
    chk("R9 recovery count", outq.size() - base, 1);
    if (outq.size() > base) chk("R9 recovery value", outq[base], gs[2]);

    // R1: a delimiter right after garbage is still recognised
    base = outq.size();
    put(16'hFFFF); put(16'h0040); put(16'h0001); put(16'h0008); put(16'h003F);
    idle(6);
    chk("R1 resync count", outq.size() - base, 1);
    if (outq.size() > base) chk("R1 resync value", outq[base], gd[63]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule